// File: doc/BRIEF.md
# Fractional-N Divide Ratio Modulator

This block produces the divide ratio for a fractional-N feedback divider, one new value on every reference clock. It takes a 7-bit integer part and an 18-bit signed fraction, where the fraction is read as frac/2^18 and covers -0.5 up to just under +0.5. A third-order cascade of three error-feedback accumulators turns the fraction into a small signed correction on each cycle. The long-term mean of the output ratio equals the integer part plus the fraction.

Software loads the fraction one byte at a time. The two lower bytes wait in staging registers. The complete word takes effect in a single cycle, when the byte holding the top two bits is written, so the loop never sees half of an update. A mode input turns the modulator off and gives plain integer division. An optional dither input adds a pseudo-random bit into the first accumulator, which breaks up idle tones when the fraction is zero or a simple ratio.

Top module: `fracn_ratio_mod`

## Requirements
- R1: While `rst` is high, `ratio` is 25 on the following clock, the active fraction is zero, and the accumulators and the dither generator return to their fixed start state.
- R2: The integer part is saturated into 25..100 before use: any value below 25 acts as 25, and any value above 100 acts as 100.
- R3: With `mod_en` low, `ratio` equals the saturated integer part on every cycle, whatever fraction is loaded, and the accumulators are held at zero.
- R4: With `mod_en` high and `dither_en` low, the mean of `ratio` over 1024 consecutive cycles is within 5/1024 of int + frac/2^18, where frac is the 18-bit two's complement active fraction.
- R5: With `mod_en` high, `dither_en` low and an active fraction of zero, starting from cleared accumulators, `ratio` equals the integer part on every cycle.
- R6: With `mod_en` high, each output lies within int-4..int+4, and the modulator correction stays in -3..+4.
- R7: Fraction bytes are written with `wr_en` high. `wr_addr` 0 loads bits 7:0 into staging, address 1 loads bits 15:8 into staging, and address 2 takes bits 17:16 from `wr_data[1:0]` and commits the full 18-bit word. Writes to addresses 0 and 1 alone leave the output unchanged.
- R8: With `dither_en` high and a zero fraction, the output moves away from the integer part within 600 cycles; with `dither_en` low it does not.
- R9: `ratio` is registered: a change on the inputs first shows on `ratio` after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| int_part | input | 7 | Integer part of the divide ratio |
| mod_en | input | 1 | 1 = fractional operation, 0 = integer division only |
| dither_en | input | 1 | 1 = add pseudo-random bit into the first accumulator |
| wr_en | input | 1 | Fraction byte write strobe |
| wr_addr | input | 2 | Fraction byte select (0 low, 1 middle, 2 top and commit) |
| wr_data | input | 8 | Fraction byte value |
| ratio | output | 8 | Divide ratio for the current reference cycle |

## Verification
The averaging test uses several fractions: a quarter-step positive value, a negative non-power-of-two value, the most negative code at the lowest integer, the largest positive code at the highest integer, minus one LSB, and zero. Together they separate correct sign handling, which borrows one from the integer part, from wrong sign handling, and they expose range errors at both ends. The zero-fraction case is checked sample by sample, because any stray carry or dither leak there shows up as an exact mismatch. Staged writes, disabled mode and dither each have their own run, and each run compares a held constant output against one that is expected to move.

// File: rtl/fracn_pkg.sv
`timescale 1ns/1ps
package fracn_pkg;
  // Correction of a three-stage cascade fits -3..+4
  typedef logic signed [3:0] corr_t;

  function automatic int clamp_int(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/fracn_shadow.sv
`timescale 1ns/1ps
module fracn_shadow #(
  parameter int FRAC_W = 18,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [FRAC_W-1:0] frac_live
);
  localparam int NBYTES  = (FRAC_W + BYTE_W - 1) / BYTE_W;
  localparam int LOW_W   = (NBYTES - 1) * BYTE_W;
  localparam int TOP_W   = FRAC_W - LOW_W;
  localparam int TOP_IDX = NBYTES - 1;

  logic [BYTE_W-1:0] stage [NBYTES-1];
  logic [LOW_W-1:0]  staged_low;
  logic              top_wr;

  assign top_wr = wr_en && (wr_addr == ADDR_W'(TOP_IDX));

  for (genvar g = 0; g < NBYTES - 1; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)                                    stage[g] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(g))    stage[g] <= wr_data;
    end
  end

  always_comb begin
    staged_low = '0;
    for (int i = 0; i < NBYTES - 1; i++)
      staged_low[i*BYTE_W +: BYTE_W] = stage[i];
  end

  always_ff @(posedge clk) begin
    if (rst)         frac_live <= '0;
    else if (top_wr) frac_live <= {wr_data[TOP_W-1:0], staged_low};
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !top_wr |=> $stable(frac_live)); // R7
endmodule

// File: rtl/fracn_lfsr.sv
`timescale 1ns/1ps
module fracn_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic bit_out
);
  logic [W-1:0] state;

  always_ff @(posedge clk) begin
    if (rst)           state <= SEED;
    else if (adv) begin
      if (state[0])    state <= (state >> 1) ^ TAPS;
      else             state <= state >> 1;
    end
  end

  assign bit_out = state[0];

  AST_LFSR_ALIVE: assert property (@(posedge clk) disable iff (rst)
    state != '0); // R8
endmodule

// File: rtl/fracn_mash.sv
`timescale 1ns/1ps
module fracn_mash
  import fracn_pkg::*;
#(
  parameter int ACC_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [ACC_W-1:0] x,
  input  logic             dith,
  output corr_t            corr
);
  logic [ACC_W-1:0] acc1, acc2, acc3;
  logic [ACC_W:0]   s1, s2, s3;
  logic             c1, c2, c3;
  logic             c2d, c3d, c3dd;
  int               tmp;

  always_comb begin
    s1 = {1'b0, acc1} + {1'b0, x} + (ACC_W+1)'(dith);
    s2 = {1'b0, acc2} + {1'b0, s1[ACC_W-1:0]};
    s3 = {1'b0, acc3} + {1'b0, s2[ACC_W-1:0]};
    c1 = s1[ACC_W];
    c2 = s2[ACC_W];
    c3 = s3[ACC_W];
    tmp = int'(c1) + int'(c2) - int'(c2d) + int'(c3) - 2 * int'(c3d) + int'(c3dd);
    corr = corr_t'(tmp);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      acc1 <= '0; acc2 <= '0; acc3 <= '0;
      c2d  <= 1'b0; c3d <= 1'b0; c3dd <= 1'b0;
    end else begin
      acc1 <= s1[ACC_W-1:0];
      acc2 <= s2[ACC_W-1:0];
      acc3 <= s3[ACC_W-1:0];
      c2d  <= c2;
      c3d  <= c3;
      c3dd <= c3d;
    end
  end

  AST_CORR_SPAN: assert property (@(posedge clk) disable iff (rst)
    (corr >= -4'sd3) && (corr <= 4'sd4)); // R6
  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !en |=> (acc1 == '0 && acc2 == '0 && acc3 == '0)); // R3
endmodule

// File: rtl/fracn_ratio_mod.sv
`timescale 1ns/1ps
module fracn_ratio_mod
  import fracn_pkg::*;
#(
  parameter int INT_W   = 7,
  parameter int FRAC_W  = 18,
  parameter int BYTE_W  = 8,
  parameter int ADDR_W  = 2,
  parameter int OUT_W   = 8,
  parameter int INT_MIN = 25,
  parameter int INT_MAX = 100,
  parameter int LFSR_W  = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INT_W-1:0]  int_part,
  input  logic              mod_en,
  input  logic              dither_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [OUT_W-1:0]  ratio
);
  localparam int SUM_W = OUT_W + 2;

  logic [FRAC_W-1:0]       frac_live;
  logic                    lfsr_bit;
  corr_t                   corr;
  logic [INT_W-1:0]        int_sat;
  logic [OUT_W-1:0]        base;
  logic signed [SUM_W-1:0] sum_s;
  logic [OUT_W-1:0]        ratio_n;

  fracn_shadow #(.FRAC_W(FRAC_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_shadow (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .frac_live(frac_live)
  );

  fracn_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst(rst), .adv(mod_en), .bit_out(lfsr_bit)
  );

  // Raw fraction bits feed the accumulators unsigned; a negative
  // fraction borrows one from the integer part instead.
  fracn_mash #(.ACC_W(FRAC_W)) u_mash (
    .clk(clk), .rst(rst), .en(mod_en), .x(frac_live),
    .dith(dither_en & lfsr_bit), .corr(corr)
  );

  always_comb begin
    int_sat = INT_W'(clamp_int(int'(int_part), INT_MIN, INT_MAX));
    base    = OUT_W'(int_sat) - OUT_W'(frac_live[FRAC_W-1]);
    sum_s   = $signed({2'b00, base}) + SUM_W'(corr);
    if (!mod_en)           ratio_n = OUT_W'(int_sat);
    else if (sum_s < 1)    ratio_n = OUT_W'(1);
    else                   ratio_n = OUT_W'(sum_s);
  end

  always_ff @(posedge clk) begin
    if (rst) ratio <= OUT_W'(INT_MIN);
    else     ratio <= ratio_n;
  end

  AST_MOD_OFF_INT: assert property (@(posedge clk) disable iff (rst)
    (!mod_en && int_part >= INT_W'(INT_MIN) && int_part <= INT_W'(INT_MAX))
      |=> ratio == OUT_W'($past(int_part))); // R3
  AST_INT_LOW_SAT: assert property (@(posedge clk) disable iff (rst)
    (!mod_en && int_part < INT_W'(INT_MIN)) |=> ratio == OUT_W'(INT_MIN)); // R2
  AST_RATIO_SPAN: assert property (@(posedge clk) disable iff (rst)
    ratio >= OUT_W'(INT_MIN - 4) && ratio <= OUT_W'(INT_MAX + 4)); // R6
endmodule

// File: tb/test_fracn_ratio_mod.sv
`timescale 1ns/1ps
module test_fracn_ratio_mod;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] int_part = 7'd40;
  logic       mod_en = 1'b0;
  logic       dither_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] ratio;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  localparam int NVEC = 6;
  localparam int VEC_INT  [NVEC] = '{41, 37, 25, 100, 60, 70};
  localparam int VEC_FRAC [NVEC] = '{65536, -35652, -131072, 131071, 0, -1};
  localparam int WIN = 1024;

  always #2 clk = ~clk;

  fracn_ratio_mod i_fracn_ratio_mod (
    .clk(clk), .rst(rst), .int_part(int_part), .mod_en(mod_en),
    .dither_en(dither_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ratio(ratio)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic set_frac(input int f);
    logic [17:0] fb;
    fb = 18'(f);
    wr(2'd0, fb[7:0]);
    wr(2'd1, fb[15:8]);
    wr(2'd2, {6'b0, fb[17:16]});
  endtask

  initial begin
    int bad;
    longint sum, diff;
    bit moved;
    #1;
    step(); step(); step();
    chk(ratio == 8'd25, "R1 reset ratio", ratio, 25);
    rst = 1'b0;

    // R9: registered output
    int_part = 7'd40; step();
    chk(ratio == 8'd40, "R9 first value", ratio, 40);
    int_part = 7'd30;
    chk(ratio == 8'd40, "R9 before edge", ratio, 40);
    step();
    chk(ratio == 8'd30, "R9 after edge", ratio, 30);

    // R2: saturation
    int_part = 7'd10;  step();
    chk(ratio == 8'd25, "R2 low sat", ratio, 25);
    int_part = 7'd120; step();
    chk(ratio == 8'd100, "R2 high sat", ratio, 100);
    int_part = 7'd127; step();
    chk(ratio == 8'd100, "R2 max code", ratio, 100);

    // R3: modulator off ignores fraction
    int_part = 7'd41;
    set_frac(65536);
    bad = 0;
    for (int i = 0; i < 20; i++) begin step(); if (ratio != 8'd41) bad++; end
    chk(bad == 0, "R3 integer only", bad, 0);

    // R4 / R5 / R6: vector table
    for (int v = 0; v < NVEC; v++) begin
      mod_en = 1'b0; dither_en = 1'b0;
      int_part = 7'(VEC_INT[v]);
      set_frac(VEC_FRAC[v]);
      step();
      mod_en = 1'b1;
      repeat (4) step();
      sum = 0; bad = 0;
      for (int i = 0; i < WIN; i++) begin
        step();
        sum += longint'(ratio);
        if (int'(ratio) < VEC_INT[v] - 4 || int'(ratio) > VEC_INT[v] + 4) bad++;
        if (VEC_FRAC[v] == 0 && int'(ratio) != VEC_INT[v]) bad += 1000;
      end
      diff = sum * 262144 - longint'(WIN) * (longint'(VEC_INT[v]) * 262144 + longint'(VEC_FRAC[v]));
      if (diff < 0) diff = -diff;
      chk(diff <= 5 * 262144, "R4 mean ratio", sum, longint'(WIN) * VEC_INT[v]);
      chk(bad < 1000, "R5 zero fraction exact", bad, 0);
      chk(bad % 1000 == 0, "R6 per-cycle span", bad, 0);
    end

    // R7: staged bytes do not apply until top write
    mod_en = 1'b0; int_part = 7'd50; set_frac(0); step();
    mod_en = 1'b1; repeat (4) step();
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'hFF);
    bad = 0;
    for (int i = 0; i < 100; i++) begin step(); if (ratio != 8'd50) bad++; end
    chk(bad == 0, "R7 staged held", bad, 0);
    wr(2'd2, 8'h01);
    moved = 0;
    for (int i = 0; i < 100; i++) begin step(); if (ratio != 8'd50) moved = 1; end
    chk(moved, "R7 commit applies", moved, 1);

    // R8: dither
    mod_en = 1'b0; set_frac(0); step();
    mod_en = 1'b1; dither_en = 1'b0;
    bad = 0;
    for (int i = 0; i < 600; i++) begin step(); if (ratio != 8'd50) bad++; end
    chk(bad == 0, "R8 dither off steady", bad, 0);
    mod_en = 1'b0; step();
    mod_en = 1'b1; dither_en = 1'b1;
    moved = 0; bad = 0;
    for (int i = 0; i < 600; i++) begin
      step();
      if (ratio != 8'd50) moved = 1;
      if (ratio < 8'd46 || ratio > 8'd54) bad++;
    end
    chk(moved, "R8 dither moves", moved, 1);
    chk(bad == 0, "R6 span with dither", bad, 0);

    // R1: reset mid-run
    rst = 1'b1; step();
    chk(ratio == 8'd25, "R1 reset again", ratio, 25);
    rst = 1'b0; mod_en = 1'b1; dither_en = 1'b0; int_part = 7'd50; step();
    bad = 0;
    for (int i = 0; i < 50; i++) begin step(); if (ratio != 8'd50) bad++; end
    chk(bad == 0, "R1 fraction cleared", bad, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule